// File: doc/BRIEF.md
# Self-Synchronizing Triple-Redundant Counter

This block holds a modulo counter as three identical copies, each with its own register, its own next-state logic and its own majority voter. Each voter is placed in the feedback path of one copy and sees all three registers, so every copy computes its next value from the agreed value and never from its own raw contents. A copy whose register was upset is therefore pulled back into agreement at the next clock edge, with no command from outside. The counter output and a lock indicator are produced by further majority voters, so a single wrong copy never shows at the outputs.

The counter only advances while enabled and while the voted lock indicator is high. Each copy carries a lock stage fed by one of three raw lock inputs, for example three clock-generator lock signals. While a copy is not yet locked, it waits for all three registered raw indicators to be high. Once it is locked, it follows their majority instead.

For fault studies, each copy has an inject strobe and a hold input, and all copies share an injection mask. A strobe XORs the mask into that copy's register at the next edge, which models a transient upset that has already been repaired. With hold also high, the same corruption is applied at every edge until hold falls, which models a persistent upset. A per-copy mismatch flag reports when that copy disagrees with the voted count.

Top module: `tmr_fb_counter`

## Requirements
- R1: In the cycle after a synchronous reset, `count_o` is 0, `locked_o` is 0 and `mismatch_o` is 3'b000.
- R2: At each clock edge where `en` and `locked_o` are both high, the voted count moves to count+1, and from LIMIT-1 or any larger value it moves to 0. Otherwise the count holds.
- R3: A strobe on `inj_strobe[i]` with `inj_hold[i]` low leaves `count_o` correct. It raises `mismatch_o[i]` for exactly one cycle, and the copy rejoins the other two at the following edge with no other input. At any edge with no strobe and no hold active, all three copies load the same value.
- R4: A strobe with `inj_hold[i]` high corrupts copy i with the mask at every edge while `inj_hold[i]` stays high. `count_o` stays correct throughout, `mismatch_o[i]` stays high, and it clears one edge after `inj_hold[i]` falls.
- R5: `mismatch_o[i]` is high exactly when copy i's register differs from `count_o`. When only copy i is injected, the flags of the other two copies stay low.
- R6: While unlocked, the lock indicator rises only two edges after all three `lock_raw` bits are high together (one register stage for the raw inputs, one for the lock state). Any pattern with a low bit keeps it low.
- R7: Once locked, the indicator stays high while at least two of the three registered `lock_raw` bits are high. It falls two edges after two or more of them go low.
- R8: With two copies held corrupted at once the output may be wrong. Once the hold is released on one of the two, the next sample shows only the still-held copy flagged, and the count then advances by one per enabled edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Count enable |
| lock_raw | input | 3 | Raw lock indicator, one bit per copy |
| inj_strobe | input | 3 | Per-copy strobe that XORs `inj_mask` into that copy at the edge |
| inj_hold | input | 3 | Per-copy hold: keeps the captured corruption applied at every edge |
| inj_mask | input | W | Bits to flip in the selected copy |
| count_o | output | W | Majority-voted counter value |
| locked_o | output | 1 | Majority-voted lock indicator |
| mismatch_o | output | 3 | Per-copy disagreement with the voted count |

## Verification
Counting and fault injection can fall on the same edge: a strobe or a held corruption is applied while `en` and lock are high. The next value is then computed from the vote and the mask is XORed on top of it. The bench provokes this by striking or holding one copy during enabled counting and by releasing holds mid-count. It judges each case by comparing the voted count with an independent modulo model and the flags with the set of copies it corrupted. Lock transitions are also made to coincide with enabled counting, so the bench checks that counting stops and resumes on the exact edge its own lock model predicts.

// File: rtl/tmr_fb_pkg.sv
package tmr_fb_pkg;

  localparam int NCOPY = 3;

  typedef logic [NCOPY-1:0] copy_vec_t;

  function automatic logic majority3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/tmr_maj_voter.sv
module tmr_maj_voter #(
  parameter int W = 8
) (
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_c,
  output logic [W-1:0] voted
);
  // Bitwise two-of-three vote.
  for (genvar b = 0; b < W; b++) begin : g_bit
    assign voted[b] = tmr_fb_pkg::majority3(in_a[b], in_b[b], in_c[b]);
  end
endmodule

// File: rtl/tmr_count_lane.sv
module tmr_count_lane #(
  parameter int W     = 8,
  parameter int LIMIT = 200
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         lock_v,
  input  logic [W-1:0] vote,
  input  logic         inj_strobe,
  input  logic         inj_hold,
  input  logic [W-1:0] inj_mask,
  output logic [W-1:0] state_q
);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] hold_mask_q;
  logic [W-1:0] flip;
  logic [W-1:0] next_val;

  // Next value is always derived from this lane's voted view, never from state_q.
  always_comb begin
    if (en && lock_v) next_val = (vote >= LAST) ? '0 : vote + W'(1);
    else              next_val = vote;
  end

  // A strobe applies the mask now; hold reapplies the captured mask each edge.
  always_comb begin
    if (inj_strobe)    flip = inj_mask;
    else if (inj_hold) flip = hold_mask_q;
    else               flip = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= '0;
      hold_mask_q <= '0;
    end else begin
      state_q     <= next_val ^ flip;
      hold_mask_q <= inj_hold ? flip : '0;
    end
  end
endmodule

// File: rtl/tmr_lock_lane.sv
module tmr_lock_lane (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  raw,
  input  tmr_fb_pkg::copy_vec_t seen_all,
  input  logic                  seen_vote,
  output logic                  seen_q,
  output logic                  lock_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      seen_q <= raw;
      // Unanimity to enter lock, majority to stay in it.
      lock_q <= lock_q ? seen_vote : (&seen_all);
    end
  end
endmodule

// File: rtl/tmr_fb_counter.sv
module tmr_fb_counter #(
  parameter int W     = 8,
  parameter int LIMIT = 200
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [2:0]   lock_raw,
  input  logic [2:0]   inj_strobe,
  input  logic [2:0]   inj_hold,
  input  logic [W-1:0] inj_mask,
  output logic [W-1:0] count_o,
  output logic         locked_o,
  output logic [2:0]   mismatch_o
);
  localparam int NC = tmr_fb_pkg::NCOPY;

  logic [W-1:0]          cnt_q [NC];
  logic [W-1:0]          cnt_vote [NC];
  tmr_fb_pkg::copy_vec_t seen_q;
  tmr_fb_pkg::copy_vec_t lock_q;
  tmr_fb_pkg::copy_vec_t seen_vote;
  tmr_fb_pkg::copy_vec_t lock_vote;

  for (genvar k = 0; k < NC; k++) begin : g_copy
    // Private voters for this copy's feedback paths.
    tmr_maj_voter #(.W(W)) u_cnt_vote (
      .in_a(cnt_q[0]), .in_b(cnt_q[1]), .in_c(cnt_q[2]), .voted(cnt_vote[k])
    );
    tmr_maj_voter #(.W(1)) u_seen_vote (
      .in_a(seen_q[0]), .in_b(seen_q[1]), .in_c(seen_q[2]), .voted(seen_vote[k])
    );
    tmr_maj_voter #(.W(1)) u_lock_vote (
      .in_a(lock_q[0]), .in_b(lock_q[1]), .in_c(lock_q[2]), .voted(lock_vote[k])
    );

    tmr_lock_lane u_lock (
      .clk       (clk),
      .rst       (rst),
      .raw       (lock_raw[k]),
      .seen_all  (seen_q),
      .seen_vote (seen_vote[k]),
      .seen_q    (seen_q[k]),
      .lock_q    (lock_q[k])
    );

    tmr_count_lane #(.W(W), .LIMIT(LIMIT)) u_cnt (
      .clk        (clk),
      .rst        (rst),
      .en         (en),
      .lock_v     (lock_vote[k]),
      .vote       (cnt_vote[k]),
      .inj_strobe (inj_strobe[k]),
      .inj_hold   (inj_hold[k]),
      .inj_mask   (inj_mask),
      .state_q    (cnt_q[k])
    );
  end

  // Output voters, fed straight from the copy registers.
  tmr_maj_voter #(.W(W)) u_out_cnt (
    .in_a(cnt_q[0]), .in_b(cnt_q[1]), .in_c(cnt_q[2]), .voted(count_o)
  );
  tmr_maj_voter #(.W(1)) u_out_lock (
    .in_a(lock_q[0]), .in_b(lock_q[1]), .in_c(lock_q[2]), .voted(locked_o)
  );

  for (genvar k = 0; k < NC; k++) begin : g_flag
    assign mismatch_o[k] = (cnt_q[k] != count_o);
  end
endmodule

// File: rtl/tmr_fb_counter_chk.sv
module tmr_fb_counter_chk #(
  parameter int W     = 8,
  parameter int LIMIT = 200
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic [2:0]   lock_raw,
  input logic [2:0]   inj_strobe,
  input logic [2:0]   inj_hold,
  input logic [W-1:0] count_o,
  input logic         locked_o,
  input logic [2:0]   mismatch_o
);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  function automatic logic [W-1:0] step(input logic [W-1:0] v);
    return (v >= LAST) ? '0 : v + W'(1);
  endfunction

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (count_o == '0 && !locked_o && mismatch_o == 3'b000));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    (en && locked_o && inj_strobe == 3'b000 && inj_hold == 3'b000 && mismatch_o == 3'b000)
      |=> count_o == step($past(count_o)));

  assert_count_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!en && inj_strobe == 3'b000 && inj_hold == 3'b000 && mismatch_o == 3'b000)
      |=> $stable(count_o));

  assert_self_sync_R3: assert property (@(posedge clk) disable iff (rst)
    (inj_strobe == 3'b000 && inj_hold == 3'b000) |=> mismatch_o == 3'b000);

  assert_flag_confined_R5: assert property (@(posedge clk) disable iff (rst)
    ($onehot0(inj_strobe | inj_hold) && mismatch_o == 3'b000)
      |=> (mismatch_o & ~$past(inj_strobe | inj_hold)) == 3'b000);

  assert_single_fault_out_R4: assert property (@(posedge clk) disable iff (rst)
    ($onehot0(inj_strobe | inj_hold) && en && locked_o && $countones(mismatch_o) <= 1)
      |=> count_o == step($past(count_o)));

  assert_unlock_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!locked_o && !(&$past(lock_raw))) |=> !locked_o);

  assert_lock_keep_R7: assert property (@(posedge clk) disable iff (rst)
    (locked_o && $countones($past(lock_raw)) >= 2) |=> locked_o);
endmodule

bind tmr_fb_counter tmr_fb_counter_chk #(.W(W), .LIMIT(LIMIT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .en         (en),
  .lock_raw   (lock_raw),
  .inj_strobe (inj_strobe),
  .inj_hold   (inj_hold),
  .count_o    (count_o),
  .locked_o   (locked_o),
  .mismatch_o (mismatch_o)
);

// File: tb/sim_tmr_fb_counter.sv
`timescale 1ns/1ps
module sim_tmr_fb_counter;
  localparam int W     = 8;
  localparam int LIMIT = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en = 1'b0;
  logic [2:0]   lock_raw = 3'b000;
  logic [2:0]   inj_strobe = 3'b000;
  logic [2:0]   inj_hold = 3'b000;
  logic [W-1:0] inj_mask = '0;
  logic [W-1:0] count_o;
  logic         locked_o;
  logic [2:0]   mismatch_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference state built from the requirements.
  int   exp_cnt = 0;
  logic [2:0] seen_m = 3'b000;
  logic lock_m = 1'b0;

  always #2.5 clk = ~clk;

  tmr_fb_counter #(.W(W), .LIMIT(LIMIT)) u0 (
    .clk(clk), .rst(rst), .en(en), .lock_raw(lock_raw),
    .inj_strobe(inj_strobe), .inj_hold(inj_hold), .inj_mask(inj_mask),
    .count_o(count_o), .locked_o(locked_o), .mismatch_o(mismatch_o)
  );

  function automatic int nxt(input int v);
    return (v >= LIMIT - 1) ? 0 : v + 1;
  endfunction

  function automatic logic maj(input logic [2:0] v);
    return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Advance one edge; the model steps first, outputs are sampled 1 ns after the edge.
  task automatic tick();
    int   c_n;
    logic l_n;
    if (rst) begin
      c_n = 0; l_n = 1'b0;
    end else begin
      c_n = (en && lock_m) ? nxt(exp_cnt) : exp_cnt;
      l_n = lock_m ? maj(seen_m) : (&seen_m);
    end
    @(posedge clk);
    #1;
    seen_m  = rst ? 3'b000 : lock_raw;
    lock_m  = l_n;
    exp_cnt = c_n;
  endtask

  task automatic t_reset();
    repeat (3) tick();
    rst = 1'b0;
    chk("R1", "count after reset", int'(count_o), 0);
    chk("R1", "locked after reset", int'(locked_o), 0);
    chk("R1", "mismatch after reset", int'(mismatch_o), 0);
  endtask

  task automatic t_lock_enter();
    en = 1'b1;
    lock_raw = 3'b110;
    repeat (4) tick();
    chk("R6", "locked with one raw low", int'(locked_o), 0);
    chk("R2", "count frozen while unlocked", int'(count_o), 0);
    lock_raw = 3'b111;
    tick();
    chk("R6", "locked one edge after unanimity", int'(locked_o), 0);
    tick();
    chk("R6", "locked two edges after unanimity", int'(locked_o), 1);
    chk("R6", "model lock agrees", int'(locked_o), int'(lock_m));
  endtask

  task automatic t_count();
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R2", "enabled count", int'(count_o), exp_cnt);
    end
    en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R2", "disabled count holds", int'(count_o), exp_cnt);
    end
  endtask

  task automatic t_wrap();
    en = 1'b1;
    while (exp_cnt != LIMIT - 1) tick();
    chk("R2", "reached last value", int'(count_o), LIMIT - 1);
    tick();
    chk("R2", "wrap to zero", int'(count_o), 0);
  endtask

  task automatic t_single();
    en = 1'b1;
    inj_mask = 8'h05;
    inj_strobe = 3'b001;
    tick();
    inj_strobe = 3'b000;
    chk("R3", "count during strike on copy 0", int'(count_o), exp_cnt);
    chk("R5", "only copy 0 flagged", int'(mismatch_o), 3'b001);
    tick();
    chk("R3", "copy 0 rejoined", int'(mismatch_o), 0);
    chk("R3", "count after rejoin", int'(count_o), exp_cnt);
    en = 1'b0;
    inj_mask = 8'h80;
    inj_strobe = 3'b100;
    tick();
    inj_strobe = 3'b000;
    chk("R5", "only copy 2 flagged", int'(mismatch_o), 3'b100);
    chk("R3", "held count during strike", int'(count_o), exp_cnt);
    tick();
    chk("R3", "copy 2 rejoined", int'(mismatch_o), 0);
  endtask

  task automatic t_persist();
    en = 1'b1;
    inj_mask = 8'h30;
    inj_strobe = 3'b010;
    inj_hold = 3'b010;
    tick();
    inj_strobe = 3'b000;
    for (int i = 0; i < 6; i++) begin
      chk("R4", "count under held fault", int'(count_o), exp_cnt);
      chk("R4", "copy 1 flag held", int'(mismatch_o), 3'b010);
      tick();
    end
    inj_hold = 3'b000;
    chk("R4", "flag before release edge", int'(mismatch_o), 3'b010);
    tick();
    chk("R4", "flag clear after release", int'(mismatch_o), 0);
    chk("R4", "count after release", int'(count_o), exp_cnt);
  endtask

  task automatic t_double();
    int v;
    en = 1'b1;
    inj_mask = 8'h01;
    inj_strobe = 3'b011;
    inj_hold = 3'b011;
    tick();
    inj_strobe = 3'b000;
    repeat (2) tick();
    inj_hold = 3'b001;
    tick();
    chk("R8", "only held copy flagged", int'(mismatch_o), 3'b001);
    v = int'(count_o);
    tick();
    chk("R8", "count advances after release", int'(count_o), nxt(v));
    chk("R8", "still only copy 0 flagged", int'(mismatch_o), 3'b001);
    inj_hold = 3'b000;
    tick();
    chk("R8", "all copies agree", int'(mismatch_o), 0);
    exp_cnt = int'(count_o);
    tick();
    chk("R2", "counting resumes from agreed value", int'(count_o), exp_cnt);
  endtask

  task automatic t_lock_keep();
    en = 1'b1;
    lock_raw = 3'b011;
    repeat (3) tick();
    chk("R7", "lock kept with two raw high", int'(locked_o), 1);
    chk("R2", "count while lock kept", int'(count_o), exp_cnt);
    lock_raw = 3'b001;
    tick();
    chk("R7", "lock one edge after loss", int'(locked_o), 1);
    tick();
    chk("R7", "lock falls two edges after loss", int'(locked_o), 0);
    lock_raw = 3'b101;
    repeat (3) tick();
    chk("R6", "no relock without unanimity", int'(locked_o), 0);
    chk("R2", "count frozen after unlock", int'(count_o), exp_cnt);
    lock_raw = 3'b111;
    repeat (3) tick();
    chk("R6", "relock after unanimity", int'(locked_o), 1);
    chk("R2", "count after relock", int'(count_o), exp_cnt);
  endtask

  initial begin
    t_reset();
    t_lock_enter();
    t_count();
    t_wrap();
    t_single();
    t_persist();
    t_double();
    t_lock_keep();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule